// File: doc/BRIEF.md
# Two-Wire Slave Command Front-End

This block is the bus-facing half of a two-wire serial slave. It oversamples the clock and data lines with a fast system clock and finds bus start and stop events. It shifts bytes in most-significant bit first and drives the open-drain data line through a single output-enable. A transaction opens with an 8-bit identification byte. That byte carries a fixed type nibble `0101` in its upper half and four pin-strapped address bits in its lower half. It has no direction bit. An instruction byte follows it.

Every accepted instruction or write byte goes to the register side as a one-cycle strobe with its data. The register side then picks the direction through a select input. For a read, the block fetches one byte from the register side for each transfer and shifts it out on the bus. It stops transmitting as soon as the master withholds its acknowledge. A busy input marks an internal nonvolatile write. While it is high, no identification byte is acknowledged.

The system clock must run at least four times faster than the bus clock.

Top module: `tw_slave`

## Requirements
- R1: After reset, `sda_oe`, `byte_stb`, `rd_req` and `standby` are all 0, so the data line is released.
- R2: Clock and data activity seen before the first START produces no acknowledge, no strobe and no drive on `sda_oe`.
- R3: An identification byte is acknowledged (SDA driven low in the ninth clock) only when bits 7:4 equal 4'b0101 and bits 3:0 equal `addr_pins`. Any other value gets no acknowledge, and later bytes are ignored until the next START.
- R4: While `busy` is 1, a matching identification byte is not acknowledged and the following bytes are ignored.
- R5: The byte after a valid identification byte is acknowledged and presented once, MSB first, on `byte_data` with `byte_stb` high for one cycle and `byte_is_data` = 0.
- R6: When `rd_sel` is 0 at the end of the instruction acknowledge, each later byte is acknowledged and strobed with `byte_is_data` = 1.
- R7: When `rd_sel` is 1 at the end of the instruction acknowledge, `rd_req` pulses and `rd_data` is captured one system clock before its MSB is driven. The byte is sent MSB first. After each master acknowledge (SDA low in the ninth clock), the next byte is fetched and sent the same way.
- R8: After a master non-acknowledge (SDA high in the ninth clock), the slave keeps SDA released until the next START or STOP.
- R9: A STOP that ends a read transaction sets `standby` to 1. A STOP after a write leaves it at 0. The next START clears it.
- R10: A START in the middle of a transaction restarts identification. The next byte is treated as an identification byte.
- R11: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired) |
| addr_pins | input | 4 | Strapped device address |
| busy | input | 1 | Internal nonvolatile write in progress |
| rd_sel | input | 1 | 1 selects the read phase after the instruction byte |
| rd_data | input | 8 | Byte to transmit, captured when `rd_req` pulses |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| byte_stb | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| byte_is_data | output | 1 | 0 for the instruction byte, 1 for a write data byte |
| rd_req | output | 1 | Pulses when `rd_data` is captured |
| standby | output | 1 | Set by a STOP that ends a read |

## Verification
The assertions check, on every cycle, the rules that hold in any state:
- `sda_oe` is released after reset and moves only while the synchronized clock is low.
- No acknowledge is raised in the identification phase while `busy` is high.
- The line stays released in the idle and ignore phases.
- Strobes last exactly one cycle.
- `standby` never coincides with driving the bus.

Only the bench scenarios can show the value-dependent behaviour. These are the acknowledge decision over all identification bytes and all address straps, the byte values and kinds on the strobe interface, and the content and order of the transmitted read bytes. They also cover the end of a read on a master non-acknowledge, the standby transitions, and recovery through a repeated START.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int          BYTE_W   = 8;
    localparam int          CNT_W    = $clog2(BYTE_W + 2);
    localparam logic [3:0]  DEV_TYPE = 4'b0101;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ID,
        PH_INSTR,
        PH_WDATA,
        PH_RDATA,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic id_match(input logic [BYTE_W-1:0] b, input logic [3:0] pins);
        return (b[BYTE_W-1 -: 4] == DEV_TYPE) && (b[3:0] == pins);
    endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync
    import tw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_p, sda_p;
    logic              scl_s, sda_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_in;
                    sda_ff <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_in};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/tw_fsm.sv
module tw_fsm
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [3:0]        addr_pins,
    input  logic              busy,
    input  logic              rd_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_is_data,
    output logic              rd_req,
    output logic              standby,
    output phase_e            phase
);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] POST_ACK = CNT_W'(BYTE_W + 1);

    logic [CNT_W-1:0]  bcnt;
    logic [BYTE_W-1:0] shreg;
    logic              load_pend;
    logic              mack;
    logic              was_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            bcnt         <= '0;
            shreg        <= '0;
            sda_oe       <= 1'b0;
            byte_stb     <= 1'b0;
            byte_data    <= '0;
            byte_is_data <= 1'b0;
            rd_req       <= 1'b0;
            standby      <= 1'b0;
            load_pend    <= 1'b0;
            mack         <= 1'b0;
            was_read     <= 1'b0;
        end else begin
            byte_stb  <= 1'b0;
            rd_req    <= 1'b0;
            load_pend <= 1'b0;
            if (ev.start) begin
                phase    <= PH_ID;
                bcnt     <= '0;
                sda_oe   <= 1'b0;
                standby  <= 1'b0;
                was_read <= 1'b0;
            end else if (ev.stop) begin
                if (was_read) standby <= 1'b1;
                was_read <= 1'b0;
                phase    <= PH_IDLE;
                bcnt     <= '0;
                sda_oe   <= 1'b0;
            end else begin
                if (load_pend) sda_oe <= ~shreg[BYTE_W-1];
                case (phase)
                    PH_ID, PH_INSTR, PH_WDATA: begin
                        if (ev.scl_rise) begin
                            if (bcnt < ACK_BIT) begin
                                shreg <= {shreg[BYTE_W-2:0], ev.sda};
                                bcnt  <= bcnt + 1'b1;
                            end else if (bcnt == ACK_BIT) begin
                                bcnt <= POST_ACK;
                            end
                        end
                        if (ev.scl_fall) begin
                            if (bcnt == ACK_BIT) begin
                                if (phase == PH_ID) begin
                                    if (id_match(shreg, addr_pins) && !busy) begin
                                        sda_oe <= 1'b1;
                                    end else begin
                                        phase <= PH_HOLD;
                                        bcnt  <= '0;
                                    end
                                end else begin
                                    sda_oe       <= 1'b1;
                                    byte_stb     <= 1'b1;
                                    byte_data    <= shreg;
                                    byte_is_data <= (phase == PH_WDATA);
                                end
                            end else if (bcnt == POST_ACK) begin
                                sda_oe <= 1'b0;
                                bcnt   <= '0;
                                if (phase == PH_ID) begin
                                    phase <= PH_INSTR;
                                end else if (phase == PH_INSTR) begin
                                    if (rd_sel) begin
                                        phase     <= PH_RDATA;
                                        shreg     <= rd_data;
                                        rd_req    <= 1'b1;
                                        load_pend <= 1'b1;
                                        was_read  <= 1'b1;
                                    end else begin
                                        phase <= PH_WDATA;
                                    end
                                end
                            end
                        end
                    end
                    PH_RDATA: begin
                        if (ev.scl_rise) begin
                            if (bcnt < ACK_BIT) begin
                                bcnt <= bcnt + 1'b1;
                            end else if (bcnt == ACK_BIT) begin
                                mack <= ~ev.sda;
                                bcnt <= POST_ACK;
                            end
                        end
                        if (ev.scl_fall) begin
                            if (bcnt != '0 && bcnt < ACK_BIT) begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end else if (bcnt == ACK_BIT) begin
                                sda_oe <= 1'b0;
                            end else if (bcnt == POST_ACK) begin
                                bcnt <= '0;
                                if (mack) begin
                                    shreg     <= rd_data;
                                    rd_req    <= 1'b1;
                                    load_pend <= 1'b1;
                                end else begin
                                    phase <= PH_HOLD;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tw_slave.sv
module tw_slave
    import tw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [3:0] addr_pins,
    input  logic       busy,
    input  logic       rd_sel,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       byte_stb,
    output logic [7:0] byte_data,
    output logic       byte_is_data,
    output logic       rd_req,
    output logic       standby
);
    bus_ev_t ev;
    phase_e  phase;

    tw_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    tw_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .addr_pins    (addr_pins),
        .busy         (busy),
        .rd_sel       (rd_sel),
        .rd_data      (rd_data),
        .sda_oe       (sda_oe),
        .byte_stb     (byte_stb),
        .byte_data    (byte_data),
        .byte_is_data (byte_is_data),
        .rd_req       (rd_req),
        .standby      (standby),
        .phase        (phase)
    );
endmodule

// File: rtl/tw_slave_chk.sv
module tw_slave_chk
    import tw_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   scl_s,
    input logic   busy,
    input logic   sda_oe,
    input logic   byte_stb,
    input logic   standby,
    input phase_e phase
);
    AST_RESET_RELEASE: assert property (@(posedge clk)
        rst |=> !sda_oe);  // R1

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));  // R11

    AST_BUSY_NO_ID_ACK: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && phase == PH_ID) |-> !$past(busy));  // R4

    AST_QUIET_PHASES: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_HOLD) |-> !sda_oe);  // R8

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> !byte_stb);  // R5

    AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (rst)
        standby |-> (!sda_oe && !byte_stb));  // R9
endmodule

bind tw_slave tw_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (ev.scl),
    .busy     (busy),
    .sda_oe   (sda_oe),
    .byte_stb (byte_stb),
    .standby  (standby),
    .phase    (phase)
);

// File: tb/tb_tw_slave.sv
`timescale 1ns/1ps
module tb_tw_slave;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] addr_pins = 4'hA;
    logic       busy = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       sda_oe, byte_stb, byte_is_data, rd_req, standby;
    logic [7:0] byte_data;
    wire        sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0] rd_idx;
    assign rd_data = 8'hC0 + rd_idx;

    logic [7:0] lg_d [16];
    logic       lg_k [16];
    int         lg_n;
    int         oe_cnt;
    int         rq_cnt;

    always #2.5 clk = ~clk;

    tw_slave dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .addr_pins(addr_pins), .busy(busy), .rd_sel(rd_sel), .rd_data(rd_data),
        .sda_oe(sda_oe), .byte_stb(byte_stb), .byte_data(byte_data),
        .byte_is_data(byte_is_data), .rd_req(rd_req), .standby(standby)
    );

    always @(posedge clk) begin
        if (rst) begin
            rd_idx <= 8'd0; lg_n <= 0; oe_cnt <= 0; rq_cnt <= 0;
        end else begin
            if (rd_req) begin rd_idx <= rd_idx + 8'd1; rq_cnt <= rq_cnt + 1; end
            if (sda_oe) oe_cnt <= oe_cnt + 1;
            if (byte_stb && lg_n < 16) begin
                lg_d[lg_n] <= byte_data;
                lg_k[lg_n] <= byte_is_data;
                lg_n <= lg_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; clks(HALF); scl = 1'b1; clks(HALF);
        sda_m = 1'b0; clks(HALF); scl = 1'b0; clks(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; clks(HALF); scl = 1'b1; clks(HALF);
        sda_m = 1'b1; clks(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; clks(HALF); scl = 1'b1; clks(HALF); scl = 1'b0;
        end
        sda_m = 1'b1; clks(HALF); scl = 1'b1; clks(3);
        ack = !sda_line; clks(HALF - 3); scl = 1'b0;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clks(HALF); scl = 1'b1; clks(3); b[i] = sda_line; clks(HALF - 3); scl = 1'b0;
        end
        clks(2); sda_m = !give_ack; clks(HALF - 2); scl = 1'b1; clks(HALF); scl = 1'b0;
        clks(2); sda_m = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit ack;
        int base;
        logic [7:0] rb;
        clks(4); rst = 1'b0; clks(4);
        // R1: reset state
        chk(!sda_oe && !byte_stb && !rd_req && !standby, "R1 reset outputs",
            {sda_oe, byte_stb, rd_req, standby}, 0);

        // R2: traffic before any START
        scl = 1'b0; clks(HALF);
        wr_byte(8'h5A, ack);
        wr_byte(8'h3C, ack);
        sda_m = 1'b1; scl = 1'b1; clks(HALF);
        chk(oe_cnt == 0 && lg_n == 0, "R2 ignored before START", oe_cnt + lg_n, 0);

        // R3: sweep every identification byte
        for (int v = 0; v < 256; v++) begin
            bus_start(); wr_byte(v[7:0], ack); bus_stop();
            chk(ack == (v == 8'h5A), "R3 id sweep", {v, 3'b0, ack}, {v, 3'b0, (v == 8'h5A)});
        end
        chk(lg_n == 0, "R3 no strobe from ids", lg_n, 0);
        // R3: sweep all address straps
        for (int p = 0; p < 16; p++) begin
            addr_pins = p[3:0];
            bus_start(); wr_byte({4'b0101, p[3:0]}, ack); bus_stop();
            chk(ack, "R3 strap match", p, 1);
            bus_start(); wr_byte({4'b0101, ~p[3:0]}, ack); bus_stop();
            chk(!ack, "R3 strap mismatch", p, 0);
        end
        addr_pins = 4'hA;
        // R3: bytes after a bad id are ignored
        base = lg_n;
        bus_start(); wr_byte(8'h5B, ack); wr_byte(8'h11, ack);
        chk(!ack && lg_n == base, "R3 ignored after bad id", lg_n - base, 0);
        bus_stop();

        // R4: busy
        busy = 1'b1; base = lg_n;
        bus_start(); wr_byte(8'h5A, ack);
        chk(!ack, "R4 busy id nack", ack, 0);
        wr_byte(8'h22, ack);
        chk(!ack && lg_n == base, "R4 busy ignores rest", lg_n - base, 0);
        bus_stop(); busy = 1'b0;

        // R5 / R6: write transaction
        rd_sel = 1'b0; base = lg_n;
        bus_start(); wr_byte(8'h5A, ack);
        chk(ack, "R5 id ack", ack, 1);
        wr_byte(8'h3C, ack);
        chk(ack, "R5 instr ack", ack, 1);
        wr_byte(8'h81, ack); chk(ack, "R6 data0 ack", ack, 1);
        wr_byte(8'h7E, ack); chk(ack, "R6 data1 ack", ack, 1);
        wr_byte(8'h00, ack); chk(ack, "R6 data2 ack", ack, 1);
        bus_stop();
        chk(lg_n - base == 4, "R6 strobe count", lg_n - base, 4);
        chk(lg_d[base] == 8'h3C && lg_k[base] == 1'b0, "R5 instr strobe",
            {lg_k[base], lg_d[base]}, 9'h03C);
        chk(lg_d[base+1] == 8'h81 && lg_k[base+1], "R6 data0", {lg_k[base+1], lg_d[base+1]}, 9'h181);
        chk(lg_d[base+2] == 8'h7E && lg_k[base+2], "R6 data1", {lg_k[base+2], lg_d[base+2]}, 9'h17E);
        chk(lg_d[base+3] == 8'h00 && lg_k[base+3], "R6 data2", {lg_k[base+3], lg_d[base+3]}, 9'h100);
        chk(!standby, "R9 no standby after write", standby, 0);

        // R10: repeated START mid-transaction
        base = lg_n;
        bus_start(); wr_byte(8'h5A, ack); wr_byte(8'h21, ack);
        bus_start(); wr_byte(8'h5A, ack);
        chk(ack, "R10 id after restart", ack, 1);
        wr_byte(8'h42, ack);
        bus_stop();
        chk(lg_n - base == 2 && lg_d[base+1] == 8'h42 && !lg_k[base+1], "R10 second instr",
            {lg_k[base+1], lg_d[base+1]}, 9'h042);

        // R7 / R8 / R9: read transaction
        rd_sel = 1'b1; base = lg_n;
        bus_start(); wr_byte(8'h5A, ack); wr_byte(8'h9F, ack);
        chk(ack && lg_d[base] == 8'h9F && !lg_k[base], "R7 read instr", lg_d[base], 8'h9F);
        rd_byte(1'b1, rb); chk(rb == 8'hC0, "R7 read byte0", rb, 8'hC0);
        rd_byte(1'b1, rb); chk(rb == 8'hC1, "R7 read byte1", rb, 8'hC1);
        rd_byte(1'b0, rb); chk(rb == 8'hC2, "R7 read byte2", rb, 8'hC2);
        chk(rq_cnt == 3, "R7 fetch count", rq_cnt, 3);
        rd_byte(1'b0, rb);
        chk(rb == 8'hFF && rq_cnt == 3, "R8 silent after nack", rb, 8'hFF);
        bus_stop();
        chk(standby, "R9 standby after read", standby, 1);
        rd_sel = 1'b0;
        bus_start();
        chk(!standby, "R9 start clears standby", standby, 0);
        bus_stop();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule